// File: doc/BRIEF.md
# Cross-Processor Sync and Doorbell Register

This block joins two processors, called side A and side B, through one 16-bit register per side. Each side writes a 4-bit value of its own into its register. The other side reads that value back in the low nibble of its own register. The two processors use this to agree on a state or a step number without a shared memory.

Each side also holds an interrupt-enable bit. A side can write a one-shot trigger bit, and that write rings a doorbell interrupt on the other side. The interrupt fires only if the other side has its enable bit set. The trigger bit is not stored. The block has no bus decode, no data queue and no interrupt controller. A write port, a read port and an interrupt line are provided per side.

Top module: `xproc_sync_reg`

## Requirements
- R1: After reset, both read ports return 0x0000 and both interrupt outputs are low.
- R2: A write from a side stores bits 11:8 of its write data. From the next cycle they read back at bits 11:8 of that side's read port.
- R3: Bits 3:0 of a side's read port always show the nibble the other side last stored at its bits 11:8. The new value appears in the cycle after the other side's write.
- R4: A write from a side stores bit 14 of its write data as that side's interrupt enable. From the next cycle it reads back at bit 14.
- R5: While side B presents a write with bit 13 set, `a_irq` is high in that same cycle exactly when side A's stored enable is 1. The same rule holds with A and B swapped. The enable value used is the one stored before the cycle, so a write to the enable in the same cycle does not count.
- R6: Bits 15, 13, 12 and 7:4 of both read ports always read zero. Write data in bits 15, 13, 12, 7:4 and 3:0 changes no stored state.
- R7: In a cycle without a write from a side, that side's stored nibble and enable keep their values.
- R8: When both sides write in the same cycle, both writes take effect. Each side's stored fields and mirrored nibble reflect the other side's write in the next cycle.
- R9: A doorbell interrupt is high only during the cycle of the triggering write. It is low in the following cycle when no new trigger arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_wr_en | input | 1 | Side A write strobe |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A register view |
| a_irq | output | 1 | Doorbell pulse to side A |
| b_wr_en | input | 1 | Side B write strobe |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B register view |
| b_irq | output | 1 | Doorbell pulse to side B |

## Verification
The block has no parameters, so the bench builds it exactly as shipped. With a 4-bit nibble on each side, all 256 pairs of nibble values can be written simultaneously from both sides. The sweep also drives junk patterns in the ignored bits and changes the enable bit on every step. All four combinations of enable states are tried for each trigger direction. The bench also covers a trigger that arrives in the same cycle as a write to the enable.

// File: rtl/xproc_sync_reg.sv
module xproc_sync_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_wr_en,
  input  logic [15:0] a_wdata,
  output logic [15:0] a_rdata,
  output logic        a_irq,
  input  logic        b_wr_en,
  input  logic [15:0] b_wdata,
  output logic [15:0] b_rdata,
  output logic        b_irq
);

  logic [3:0] a_nib, b_nib;
  logic       a_ien, b_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_nib <= '0;
      a_ien <= 1'b0;
    end else if (a_wr_en) begin
      a_nib <= a_wdata[11:8];
      a_ien <= a_wdata[14];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_nib <= '0;
      b_ien <= 1'b0;
    end else if (b_wr_en) begin
      b_nib <= b_wdata[11:8];
      b_ien <= b_wdata[14];
    end
  end

  assign a_rdata = {1'b0, a_ien, 2'b00, a_nib, 4'b0000, b_nib};
  assign b_rdata = {1'b0, b_ien, 2'b00, b_nib, 4'b0000, a_nib};

  assign a_irq = b_wr_en & b_wdata[13] & a_ien;
  assign b_irq = a_wr_en & a_wdata[13] & b_ien;

  logic unused_bits;
  assign unused_bits = &{1'b0, a_wdata[15], a_wdata[12], a_wdata[7:0],
                         b_wdata[15], b_wdata[12], b_wdata[7:0]};

  // R2
  a_nib_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_en |=> a_rdata[11:8] == $past(a_wdata[11:8]));
  // R2
  b_nib_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_en |=> b_rdata[11:8] == $past(b_wdata[11:8]));
  // R3
  a_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_en |=> a_rdata[3:0] == $past(b_wdata[11:8]));
  // R3
  b_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_en |=> b_rdata[3:0] == $past(a_wdata[11:8]));
  // R4
  a_ien_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_en |=> a_rdata[14] == $past(a_wdata[14]));
  // R4
  b_ien_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_en |=> b_rdata[14] == $past(b_wdata[14]));
  // R5
  a_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq |-> (b_wr_en && b_wdata[13] && a_rdata[14]));
  // R5
  b_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq |-> (a_wr_en && a_wdata[13] && b_rdata[14]));
  // R5
  a_irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr_en && b_wdata[13] && a_rdata[14]) |-> a_irq);
  // R6
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata[15:12] & 4'b1011) == 4'b0 && a_rdata[7:4] == 4'b0 &&
    (b_rdata[15:12] & 4'b1011) == 4'b0 && b_rdata[7:4] == 4'b0);
  // R7
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_wr_en |=> $stable(a_rdata[15:4]));
  // R7
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_wr_en |=> $stable(b_rdata[15:4]));

endmodule

// File: tb/xproc_sync_reg_test.sv
module xproc_sync_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [3:0] m_an = '0, m_bn = '0;
  logic m_ae = 1'b0, m_be = 1'b0;

  always #2 clk = ~clk;

  xproc_sync_reg uut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] view(input logic e, input logic [3:0] own, input logic [3:0] peer);
    return {1'b0, e, 2'b00, own, 4'b0000, peer};
  endfunction

  // drive one cycle; check irq in the write cycle, state and irq after it
  task automatic cyc(input logic ae, input logic [15:0] ad, input logic be, input logic [15:0] bd, input string tag);
    logic ea, eb;
    @(negedge clk);
    a_wr_en = ae; a_wdata = ad; b_wr_en = be; b_wdata = bd;
    ea = be & bd[13] & m_ae;
    eb = ae & ad[13] & m_be;
    #1;
    chk({tag, " R5 a_irq"}, {15'b0, a_irq}, {15'b0, ea});
    chk({tag, " R5 b_irq"}, {15'b0, b_irq}, {15'b0, eb});
    @(posedge clk);
    if (ae) begin m_an = ad[11:8]; m_ae = ad[14]; end
    if (be) begin m_bn = bd[11:8]; m_be = bd[14]; end
    #1;
    a_wr_en = 1'b0; b_wr_en = 1'b0;
    #1;
    chk({tag, " R2 R3 R4 R6 R8 a_rdata"}, a_rdata, view(m_ae, m_an, m_bn));
    chk({tag, " R2 R3 R4 R6 R8 b_rdata"}, b_rdata, view(m_be, m_bn, m_an));
    chk({tag, " R9 irq after"}, {14'b0, a_irq, b_irq}, 16'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 a_rdata", a_rdata, 16'h0);
    chk("R1 b_rdata", b_rdata, 16'h0);
    chk("R1 irqs", {14'b0, a_irq, b_irq}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 full sweep of nibble pairs with junk in ignored bits
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] ad, bd;
        ad = {i[0], i[1] ^ j[0], 1'b0, j[1], i[3:0], j[3:0], ~i[3:0]};
        bd = {j[2], j[0] ^ i[2], 1'b0, i[3], j[3:0], i[3:0] ^ j[3:0], j[3:0]};
        cyc(1'b1, ad, 1'b1, bd, "sweep");
      end
    end

    // R7 one side writes, other holds
    for (int k = 0; k < 16; k++) begin
      cyc(1'b1, {1'b0, k[0], 2'b00, k[3:0], 8'hFF}, 1'b0, 16'hFFFF, "R7 a-only");
      cyc(1'b0, 16'hFFFF, 1'b1, {1'b1, ~k[0], 2'b11, ~k[3:0], 8'h5A}, "R7 b-only");
    end

    // R5 R9 doorbell across all enable combinations
    for (int ea = 0; ea < 2; ea++) begin
      for (int eb = 0; eb < 2; eb++) begin
        cyc(1'b1, {1'b0, ea[0], 2'b00, 4'h3, 8'h00}, 1'b1, {1'b0, eb[0], 2'b00, 4'hC, 8'h00}, "R5 setup");
        cyc(1'b1, {1'b0, ea[0], 1'b1, 1'b0, 4'h3, 8'h00}, 1'b0, 16'h0, "R5 ring b");
        cyc(1'b0, 16'h0, 1'b1, {1'b0, eb[0], 1'b1, 1'b0, 4'hC, 8'h00}, "R5 ring a");
        cyc(1'b1, {1'b0, ea[0], 1'b1, 1'b0, 4'h3, 8'h00}, 1'b1, {1'b0, eb[0], 1'b1, 1'b0, 4'hC, 8'h00}, "R5 ring both");
      end
    end

    // R5 enable written in same cycle as trigger uses the old enable
    cyc(1'b1, 16'h0000, 1'b1, 16'h0000, "R5 clear");
    cyc(1'b1, 16'h4000, 1'b1, 16'h2000, "R5 late enable a");
    cyc(1'b1, 16'h2000, 1'b1, 16'h0000, "R5 enable off b old on");
    cyc(1'b1, 16'h0000, 1'b1, 16'h2000, "R5 now off");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule